// File: doc/BRIEF.md
# Fine-Scroll Character Pixel Serialiser

This block turns a stream of font bytes into one pixel bit per dot clock for a character-based display. A per-cell dot down-counter, reloaded from the fine-scroll setting, decides in which dot the next font byte enters an 8-bit shift register. The period of a character cell is therefore the fine-scroll value plus one dots. Each load also advances a line-buffer read pointer by one character, and that pointer addresses the byte that the next load will take.

A second down-counter is loaded with the displayed-dots setting at every load. While it is non-zero the register shifts left, so bits leave most significant first. When it reaches zero the register is cleared. A cell can therefore show fewer dots than the font holds, and the rest of the cell is padded with blank dots. The pixel output is gated by the horizontal display enable input. A low enable also resets the counters and the read pointer, so that every line starts cleanly.

A small state machine chooses the shifter operation in each dot. The state **IDLE** means the display enable is low. **SHOW** means the visible part of a cell is being shifted. **PAD** means the visible part is done and the register holds zero until the next load. The transitions are as follows. From any state, a low enable moves to IDLE. Any load moves to SHOW. SHOW moves to PAD on the first non-load dot in which the displayed-dots counter is zero. Every other case stays in the same state.

Top module: `pxs_fine_scroller`

## Requirements
- R1: After reset `pix`, `rd_adv` and `rd_ptr` are all zero.
- R2: A loaded font byte is emitted from bit 7 downwards, one bit per clock. With `fine_scroll`=7 and `cell_dots`=7 all eight bits appear and the next byte follows at once.
- R3: `cell_dots` holds the number of visible dots minus one. After the bits font[7] down to font[7-cell_dots] have been emitted, `pix` is 0 for the rest of the cell.
- R4: A new font byte is loaded every `fine_scroll`+1 clocks. If that period is shorter than the visible width, the cell is cut off at the load.
- R5: A `cell_dots` value above 7 behaves as 7, so a cell shows at most 8 dots.
- R6: `rd_adv` is high for exactly one clock per load, and `rd_ptr` increments after each load. While `hde` is low, `rd_ptr` is held at 0.
- R7: `pix` is 0 in any cycle in which `hde` is low, whatever the register holds.
- R8: The first load of a line happens at the first clock edge with `hde` high. `pix` is therefore 0 in the first enabled cycle, and the first cell's bit 7 appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hde | input | 1 | Horizontal display enable |
| fine_scroll | input | 4 | Reload value of the dot counter (cell period minus one) |
| cell_dots | input | 4 | Displayed dots per cell minus one |
| font_byte | input | 8 | Font byte at `rd_ptr` in the line buffer |
| rd_ptr | output | 7 | Line-buffer character index |
| rd_adv | output | 1 | Load strobe; advances the read pointer |
| pix | output | 1 | Serial pixel bit |

## Verification
The assertions assume that `font_byte` is the line-buffer entry at `rd_ptr` during the load dot. They also assume that `fine_scroll` and `cell_dots` are sampled only at loads, so changes to them between loads are legal but only take effect at the next load. The stimulus keeps within this. It models the line buffer as a combinational lookup on `rd_ptr`. It changes the two settings only while `hde` is low, between lines. Each line is held for a whole number of cells plus the initial blank dot, so that every expected bit falls inside a complete cell.

// File: rtl/pxs_pkg.sv
package pxs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHOW,
        ST_PAD
    } pxs_state_t;

    typedef enum logic [1:0] {
        OP_CLEAR,
        OP_LOAD,
        OP_SHIFT
    } pxs_op_t;
endpackage

// File: rtl/pxs_dot_timer.sv
module pxs_dot_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             load
);
    logic [CNT_W-1:0] cnt;

    assign load = run && (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run)           cnt <= '0;
        else if (cnt == '0)      cnt <= reload;
        else                     cnt <= cnt - 1'b1;
    end

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(reload)));
    assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));
endmodule

// File: rtl/pxs_vis_timer.sv
module pxs_vis_timer #(
    parameter int CNT_W  = 4,
    parameter int FONT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] width,
    output logic             expired
);
    localparam logic [CNT_W-1:0] MAX_VIS = CNT_W'(FONT_W - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] width_lim;

    always_comb begin
        if (width > MAX_VIS) width_lim = MAX_VIS;
        else                 width_lim = width;
    end

    assign expired = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (!run)        cnt <= '0;
        else if (load)        cnt <= width_lim;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assert_width_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= MAX_VIS);
    assert_width_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && load && $past(1'b1) && width <= MAX_VIS) |=> (cnt == $past(width)));
endmodule

// File: rtl/pxs_shifter.sv
module pxs_shifter
    import pxs_pkg::*;
#(
    parameter int FONT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pxs_op_t           op,
    input  logic [FONT_W-1:0] din,
    output logic              msb
);
    logic [FONT_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else begin
            unique case (op)
                OP_LOAD:  sreg <= din;
                OP_SHIFT: sreg <= {sreg[FONT_W-2:0], 1'b0};
                default:  sreg <= '0;
            endcase
        end
    end

    assign msb = sreg[FONT_W-1];

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_LOAD) |=> (sreg == $past(din)));
    assert_msb_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SHIFT) |=> (msb == $past(sreg[FONT_W-2])));
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CLEAR) |=> (sreg == '0));
endmodule

// File: rtl/pxs_fine_scroller.sv
module pxs_fine_scroller
    import pxs_pkg::*;
#(
    parameter int FONT_W = 8,
    parameter int CNT_W  = 4,
    parameter int PTR_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hde,
    input  logic [CNT_W-1:0]  fine_scroll,
    input  logic [CNT_W-1:0]  cell_dots,
    input  logic [FONT_W-1:0] font_byte,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              rd_adv,
    output logic              pix
);
    pxs_state_t state, state_nx;
    pxs_op_t    op;
    logic       load;
    logic       expired;
    logic       msb;

    pxs_dot_timer #(.CNT_W(CNT_W)) u_dot (
        .clk(clk), .rst_n(rst_n), .run(hde),
        .reload(fine_scroll), .load(load)
    );

    pxs_vis_timer #(.CNT_W(CNT_W), .FONT_W(FONT_W)) u_vis (
        .clk(clk), .rst_n(rst_n), .run(hde), .load(load),
        .width(cell_dots), .expired(expired)
    );

    pxs_shifter #(.FONT_W(FONT_W)) u_sh (
        .clk(clk), .rst_n(rst_n), .op(op), .din(font_byte), .msb(msb)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!hde) begin
            state_nx = ST_IDLE;
        end else if (load) begin
            state_nx = ST_SHOW;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_SHOW: if (expired) state_nx = ST_PAD;
                ST_PAD:  state_nx = ST_PAD;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output logic
    always_comb begin
        op = OP_CLEAR;
        if (hde) begin
            if (load) begin
                op = OP_LOAD;
            end else begin
                unique case (state)
                    ST_SHOW: op = expired ? OP_CLEAR : OP_SHIFT;
                    default: op = OP_CLEAR;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rd_ptr <= '0;
        else if (!hde) rd_ptr <= '0;
        else if (load) rd_ptr <= rd_ptr + 1'b1;
    end

    assign rd_adv = load;
    assign pix    = msb & hde;

    assert_blank_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !hde |-> !pix);
    assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_adv && hde) |=> (rd_ptr == PTR_W'($past(rd_ptr) + 1'b1)));
    assert_ptr_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !hde |=> (rd_ptr == '0));
    assert_pad_blank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PAD) |-> !pix);
    assert_first_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hde) |-> rd_adv);
endmodule

// File: tb/sim_pxs_fine_scroller.sv
module sim_pxs_fine_scroller;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hde = 1'b0;
    logic [3:0] fine_scroll = 4'd7;
    logic [3:0] cell_dots = 4'd7;
    logic [7:0] font_byte;
    logic [6:0] rd_ptr;
    logic       rd_adv;
    logic       pix;

    logic [7:0] lb [0:127];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    int adv_seen = 0;
    bit exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    assign font_byte = lb[rd_ptr];

    pxs_fine_scroller u0 (
        .clk(clk), .rst_n(rst_n), .hde(hde), .fine_scroll(fine_scroll),
        .cell_dots(cell_dots), .font_byte(font_byte), .rd_ptr(rd_ptr),
        .rd_adv(rd_adv), .pix(pix)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard at every enabled falling edge
    always @(negedge clk) begin
        if (mon_on) begin
            if (rd_adv) adv_seen++;
            if (exp_q.size() == 0) begin
                check("R2 queue underflow", 1, 0);
            end else begin
                check(tag_q.pop_front(), int'(pix), int'(exp_q.pop_front()));
            end
        end
    end

    // driver: one line of n cells with the given settings
    task automatic run_line(input int f, input int cd, input int n, input string req);
        int len;
        int eff;
        len = 1 + n * (f + 1);
        eff = (cd > 7) ? 7 : cd;
        exp_q.push_back(1'b0);
        tag_q.push_back("R8 first enabled dot blank");
        for (int t = 1; t < len; t++) begin
            int c;
            int j;
            c = (t - 1) / (f + 1);
            j = (t - 1) % (f + 1);
            exp_q.push_back((j <= eff) ? lb[c][7 - j] : 1'b0);
            tag_q.push_back((j <= eff) ? req : {req, " pad"});
        end
        @(posedge clk); #1;
        fine_scroll = 4'(f);
        cell_dots = 4'(cd);
        adv_seen = 0;
        hde = 1'b1;
        mon_on = 1'b1;
        repeat (len - 1) @(posedge clk);
        @(negedge clk);
        #1;
        check("R6 rd_ptr at line end", int'(rd_ptr), n);
        @(posedge clk); #1;
        hde = 1'b0;
        mon_on = 1'b0;
        check("R6 rd_adv pulses per line", adv_seen, n + 1);
        check("R2 scoreboard drained", exp_q.size(), 0);
        @(negedge clk);
        check("R7 pix gated while hde low", int'(pix), 0);
        @(negedge clk);
        check("R6 rd_ptr cleared with hde low", int'(rd_ptr), 0);
        repeat (2) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) lb[i] = 8'((i * 53 + 167) ^ (i << 3));
        lb[0] = 8'hA5;
        lb[1] = 8'hFF;
        lb[2] = 8'h81;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pix", int'(pix), 0);
        check("R1 reset rd_adv", int'(rd_adv), 0);
        check("R1 reset rd_ptr", int'(rd_ptr), 0);
        #1 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        run_line(7, 7, 6, "R2 msb-first full cell");
        run_line(7, 4, 5, "R3 narrow cell");
        run_line(10, 2, 4, "R3 narrow wide-period cell");
        run_line(3, 7, 8, "R4 short period truncation");
        run_line(12, 13, 3, "R5 width clamp");
        run_line(0, 0, 10, "R4 single-dot period");
        run_line(15, 9, 3, "R5 clamp long period");
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule